// File: doc/BRIEF.md
# Quadrature Edge-Strobe Direction Counter

This block turns the two square-wave phase outputs of a rotary shaft encoder into a signed position count. Each level change on either phase counts once, so a full encoder cycle gives four counts. The two phases sit a quarter period apart. Which phase leads sets the direction of travel.

Both phases first pass through a synchronizer. A change detector then compares the registered parity of the two phases with its value one cycle earlier. Each accepted transition starts a low-going count strobe of fixed width. At the same time the block latches the new A level and the B level from just before the transition. The direction bit is the XNOR of these two latched values. It stays frozen for twice the strobe width, so it is stable when the counter commits on the strobe's rising (trailing) edge.

Two kinds of input change are rejected. One is a transition that arrives while that hold window is still open. The other is a change of both phases in the same cycle. Neither is counted, and both set a sticky error flag.

Top module: `quad_strobe_counter`

## Requirements
- R1: After synchronous reset the outputs are as follows: the count is 0, the strobe is high (inactive), the error flag is 0, and dir_up is 1.
- R2: Each accepted single-phase transition drives cnt_strobe_n low for exactly STB_W clock cycles. The strobe first reads low after the third rising clock edge that follows the input change: two synchronizer edges, then one detection edge.
- R3: dir_up equals XNOR of the A level after the accepted transition with the B level just before it. A value of 1 means count up.
- R4: In the A-leading order {A,B} = 00→10→11→01→00, each step decrements the count by 1. In the B-leading order 00→01→11→10→00, each step increments it by 1. Either way a full cycle moves the count by 4.
- R5: pos_count changes only at the clock edge where cnt_strobe_n returns high. It is unchanged during the strobe and between strobes.
- R6: dir_up does not change while cnt_strobe_n is low. It stays fixed for 2·STB_W cycles from the start of each accepted transition.
- R7: A change of both A and B in the same synchronized cycle sets err_flag. It produces no strobe and leaves the count unchanged.
- R8: A single-phase transition detected within 2·STB_W cycles of the previously accepted one sets err_flag and is not counted.
- R9: err_flag stays set once raised, whatever later valid transitions occur, until synchronous reset clears it.
- R10: The count is a CNT_W-bit two's-complement value that wraps. One down step from 0 gives all ones (-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| pos_count | output | CNT_W | Signed position count |
| dir_up | output | 1 | Direction bit, 1 = count up |
| cnt_strobe_n | output | 1 | Count strobe, active low, STB_W cycles wide |
| err_flag | output | 1 | Sticky error for rejected transitions |

## Verification
The bound checker checks several properties on every clock. It measures every low strobe run against STB_W. It confirms that the count moves only on a strobe rising edge and then by exactly one step in the latched direction. It also confirms that dir_up holds still while the strobe is low and that the error flag never drops outside reset.

The bench's scenarios cover the rest. They check the synchronizer-plus-detector latency and the XNOR polarity for both rotation orders. They also cover rejection of dual-phase and too-fast transitions, wraparound below zero, and clearing of the error flag by reset, with a cycle-level reference model compared on every clock.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

   // One sample of both encoder phases; a is the upper bit.
   typedef struct packed {
      logic a;
      logic b;
   } qsc_ab_t;

   // Bits needed to hold a down-counter that starts at span.
   function automatic int unsigned qsc_tmr_w(input int unsigned span);
      return (span < 2) ? 1 : $clog2(span + 1);
   endfunction

endpackage

// File: rtl/qsc_sync.sv
module qsc_sync
   import qsc_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic    clk,
   input  logic    rst,
   input  qsc_ab_t raw,
   output qsc_ab_t synced
);

   qsc_ab_t [STAGES-1:0] pipe;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) pipe[0] <= '0;
               else     pipe[0] <= raw;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) pipe[i] <= '0;
               else     pipe[i] <= pipe[i-1];
            end
         end
      end
   endgenerate

   assign synced = pipe[STAGES-1];

endmodule

// File: rtl/qsc_change.sv
module qsc_change
   import qsc_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  qsc_ab_t cur,
   output logic    single_chg,
   output logic    dual_chg,
   output logic    a_after,
   output logic    b_before
);

   qsc_ab_t prev;
   logic    par_cur;
   logic    par_prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= '0;
      else     prev <= cur;
   end

   // Parity flips on a one-phase change and holds on a two-phase change.
   assign par_cur    = cur.a ^ cur.b;
   assign par_prev   = prev.a ^ prev.b;
   assign single_chg = par_cur ^ par_prev;
   assign dual_chg   = (cur.a ^ prev.a) & (cur.b ^ prev.b);
   assign a_after    = cur.a;
   assign b_before   = prev.b;

endmodule

// File: rtl/qsc_timer.sv
module qsc_timer
   import qsc_pkg::*;
#(
   parameter int unsigned STB_W = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic start_req,
   output logic accept,
   output logic busy,
   output logic strobe_n,
   output logic commit
);

   localparam int unsigned HOLD_W = 2 * STB_W;
   localparam int unsigned TW     = qsc_tmr_w(HOLD_W);

   logic [TW-1:0] stb_left;
   logic [TW-1:0] hold_left;

   assign busy     = (hold_left != '0);
   assign accept   = start_req & ~busy;
   assign strobe_n = (stb_left == '0);
   assign commit   = (stb_left == TW'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         stb_left  <= '0;
         hold_left <= '0;
      end else if (accept) begin
         stb_left  <= TW'(STB_W);
         hold_left <= TW'(HOLD_W);
      end else begin
         if (stb_left != '0)  stb_left  <= stb_left - TW'(1);
         if (hold_left != '0) hold_left <= hold_left - TW'(1);
      end
   end

endmodule

// File: rtl/qsc_dir.sv
module qsc_dir (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic a_after,
   input  logic b_before,
   output logic dir_up
);

   logic a_cap;
   logic b_hold;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_cap  <= 1'b0;
         b_hold <= 1'b0;
      end else if (load) begin
         a_cap  <= a_after;
         b_hold <= b_before;
      end
   end

   assign dir_up = ~(a_cap ^ b_hold);

endmodule

// File: rtl/qsc_count.sv
module qsc_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    commit,
   input  logic                    dir_up,
   output logic signed [CNT_W-1:0] count
);

   localparam logic signed [CNT_W-1:0] STEP = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst)         count <= '0;
      else if (commit) count <= dir_up ? count + STEP : count - STEP;
   end

endmodule

// File: rtl/quad_strobe_counter.sv
module quad_strobe_counter
   import qsc_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned STB_W       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    enc_a,
   input  logic                    enc_b,
   output logic signed [CNT_W-1:0] pos_count,
   output logic                    dir_up,
   output logic                    cnt_strobe_n,
   output logic                    err_flag
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("quad_strobe_counter: CNT_W must be at least 2");
      end
      if (STB_W < 1) begin : g_bad_stb
         $error("quad_strobe_counter: STB_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("quad_strobe_counter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   qsc_ab_t raw_ab;
   qsc_ab_t sync_ab;
   logic    single_chg;
   logic    dual_chg;
   logic    a_after;
   logic    b_before;
   logic    accept;
   logic    busy;
   logic    commit;

   assign raw_ab.a = enc_a;
   assign raw_ab.b = enc_b;

   qsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .raw    (raw_ab),
      .synced (sync_ab)
   );

   qsc_change u_change (
      .clk        (clk),
      .rst        (rst),
      .cur        (sync_ab),
      .single_chg (single_chg),
      .dual_chg   (dual_chg),
      .a_after    (a_after),
      .b_before   (b_before)
   );

   qsc_timer #(.STB_W(STB_W)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .start_req (single_chg),
      .accept    (accept),
      .busy      (busy),
      .strobe_n  (cnt_strobe_n),
      .commit    (commit)
   );

   qsc_dir u_dir (
      .clk      (clk),
      .rst      (rst),
      .load     (accept),
      .a_after  (a_after),
      .b_before (b_before),
      .dir_up   (dir_up)
   );

   qsc_count #(.CNT_W(CNT_W)) u_count (
      .clk    (clk),
      .rst    (rst),
      .commit (commit),
      .dir_up (dir_up),
      .count  (pos_count)
   );

   always_ff @(posedge clk) begin
      if (rst) err_flag <= 1'b0;
      else     err_flag <= err_flag | dual_chg | (single_chg & busy);
   end

endmodule

// File: rtl/qsc_checker.sv
module qsc_checker #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned STB_W = 4
) (
   input logic                    clk,
   input logic                    rst,
   input logic signed [CNT_W-1:0] pos_count,
   input logic                    dir_up,
   input logic                    cnt_strobe_n,
   input logic                    err_flag
);

   int unsigned low_run;

   always_ff @(posedge clk) begin
      if (rst || cnt_strobe_n) low_run <= 0;
      else                     low_run <= low_run + 1;
   end

   assert_strobe_width_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(cnt_strobe_n) |-> (low_run == STB_W));

   assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(cnt_strobe_n) |->
         (pos_count == ($past(dir_up) ? CNT_W'($past(pos_count) + 1)
                                      : CNT_W'($past(pos_count) - 1))));

   assert_commit_on_trailing_R5: assert property (@(posedge clk) disable iff (rst)
      !$stable(pos_count) |-> $rose(cnt_strobe_n));

   assert_dir_held_R6: assert property (@(posedge clk) disable iff (rst)
      (!cnt_strobe_n && $past(!cnt_strobe_n)) |-> $stable(dir_up));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      $past(err_flag) |-> err_flag);

endmodule

bind quad_strobe_counter qsc_checker #(.CNT_W(CNT_W), .STB_W(STB_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .pos_count    (pos_count),
   .dir_up       (dir_up),
   .cnt_strobe_n (cnt_strobe_n),
   .err_flag     (err_flag)
);

// File: tb/quad_strobe_counter_test.sv
`timescale 1ns/1ps
module quad_strobe_counter_test;

   localparam int unsigned CNT_W = 16;
   localparam int unsigned STB_W = 4;
   localparam int unsigned GAP   = 3 * STB_W;

   logic                    clk = 1'b0;
   logic                    rst = 1'b1;
   logic                    enc_a = 1'b0;
   logic                    enc_b = 1'b0;
   logic signed [CNT_W-1:0] pos_count;
   logic                    dir_up;
   logic                    cnt_strobe_n;
   logic                    err_flag;

   int  checks   = 0;
   int  failures = 0;
   bit  cmp_on   = 1'b0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   quad_strobe_counter #(.CNT_W(CNT_W), .STB_W(STB_W), .SYNC_STAGES(2)) uut (
      .clk          (clk),
      .rst          (rst),
      .enc_a        (enc_a),
      .enc_b        (enc_b),
      .pos_count    (pos_count),
      .dir_up       (dir_up),
      .cnt_strobe_n (cnt_strobe_n),
      .err_flag     (err_flag)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: phases {a,b}, delay queue, timers as integers.
   bit [1:0] m_q1, m_q2, m_prev;
   int       m_stb, m_hold, m_pos;
   bit       m_anew, m_bold, m_err;

   always @(posedge clk) begin
      bit ca, cb, take;
      if (rst) begin
         m_q1 = 0; m_q2 = 0; m_prev = 0;
         m_stb = 0; m_hold = 0; m_pos = 0;
         m_anew = 0; m_bold = 0; m_err = 0;
      end else begin
         ca   = m_q2[1] != m_prev[1];
         cb   = m_q2[0] != m_prev[0];
         take = (ca != cb) && (m_hold == 0);
         if ((ca && cb) || ((ca || cb) && m_hold > 0)) m_err = 1;
         if (m_stb == 1) m_pos = (m_pos + ((m_anew == m_bold) ? 1 : -1)) & 32'hFFFF;
         if (take) begin
            m_stb  = STB_W;
            m_hold = 2 * STB_W;
            m_anew = m_q2[1];
            m_bold = m_prev[0];
         end else begin
            if (m_stb > 0)  m_stb--;
            if (m_hold > 0) m_hold--;
         end
         m_prev = m_q2;
         m_q2   = m_q1;
         m_q1   = {enc_a, enc_b};
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         chk($unsigned(pos_count) == m_pos[15:0], "R4 model count", $unsigned(pos_count), m_pos[15:0]);
         chk(cnt_strobe_n == (m_stb == 0), "R2 model strobe", cnt_strobe_n, (m_stb == 0));
         chk(err_flag == m_err, "R7 model error", err_flag, m_err);
         chk(dir_up == (m_anew == m_bold), "R3 model direction", dir_up, (m_anew == m_bold));
      end
   end

   task automatic move(input bit a, input bit b, input int unsigned wait_cyc);
      @(negedge clk);
      enc_a = a;
      enc_b = b;
      repeat (wait_cyc) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst    = 1'b0;
      cmp_on = 1'b1;

      // R1 reset state
      chk($unsigned(pos_count) == 0, "R1 count", $unsigned(pos_count), 0);
      chk(cnt_strobe_n == 1'b1, "R1 strobe", cnt_strobe_n, 1);
      chk(err_flag == 1'b0, "R1 error", err_flag, 0);
      chk(dir_up == 1'b1, "R1 dir", dir_up, 1);

      // R2 latency and width, R5 commit point, R10 wrap, R3 polarity
      @(negedge clk);
      enc_a = 1'b1;
      repeat (2) @(negedge clk);
      chk(cnt_strobe_n == 1'b1, "R2 strobe still high after two edges", cnt_strobe_n, 1);
      @(negedge clk);
      chk(cnt_strobe_n == 1'b0, "R2 strobe low after third edge", cnt_strobe_n, 0);
      for (int i = 1; i < STB_W; i++) begin
         @(negedge clk);
         chk(cnt_strobe_n == 1'b0, "R2 strobe held low", cnt_strobe_n, 0);
         chk($unsigned(pos_count) == 0, "R5 count unchanged mid-strobe", $unsigned(pos_count), 0);
      end
      @(negedge clk);
      chk(cnt_strobe_n == 1'b1, "R2 strobe released", cnt_strobe_n, 1);
      chk($unsigned(pos_count) == 16'hFFFF, "R10 wrap below zero", $unsigned(pos_count), 16'hFFFF);
      chk(dir_up == 1'b0, "R3 A-leading gives down", dir_up, 0);
      repeat (GAP) @(negedge clk);

      // R4 rest of the A-leading cycle
      move(1, 1, GAP);
      move(0, 1, GAP);
      move(0, 0, GAP);
      chk($unsigned(pos_count) == 16'hFFFC, "R4 A-leading cycle", $unsigned(pos_count), 16'hFFFC);

      // R4 B-leading, two cycles
      for (int c = 0; c < 2; c++) begin
         move(0, 1, GAP);
         move(1, 1, GAP);
         move(1, 0, GAP);
         move(0, 0, GAP);
      end
      chk($unsigned(pos_count) == 4, "R4 B-leading cycles", $unsigned(pos_count), 4);
      chk(dir_up == 1'b1, "R3 B-leading gives up", dir_up, 1);

      // R7 simultaneous change
      move(1, 1, GAP);
      chk(err_flag == 1'b1, "R7 dual change flags", err_flag, 1);
      chk($unsigned(pos_count) == 4, "R7 dual change not counted", $unsigned(pos_count), 4);

      // R9 flag stays while valid steps continue
      move(1, 0, GAP);
      chk($unsigned(pos_count) == 5, "R9 valid step after error counts", $unsigned(pos_count), 5);
      chk(err_flag == 1'b1, "R9 error still set", err_flag, 1);
      move(0, 0, GAP);
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk(err_flag == 1'b0, "R9 reset clears error", err_flag, 0);
      chk($unsigned(pos_count) == 0, "R1 reset clears count", $unsigned(pos_count), 0);

      // R8 transition inside the hold window
      move(0, 1, 2);
      move(1, 1, GAP + 2);
      chk(err_flag == 1'b1, "R8 fast transition flags", err_flag, 1);
      chk($unsigned(pos_count) == 1, "R8 fast transition not counted", $unsigned(pos_count), 1);

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule